// File: doc/BRIEF.md
# Refresh-Aware DRAM Command Arbiter

This block chooses, once per clock, the single command a DRAM channel receives. There are three possible sources: a refresh (all-bank or single-bank), a precharge that the arbiter raises on its own to close a bank ahead of a refresh, and the one read/write transaction waiting at a valid/ready handshake. A refresh generator upstream supplies a pending flag, the number of refreshes currently owed, and the bank it wants refreshed next. A row tracker supplies a vector that shows which banks hold an open row.

The owed count sets the policy. With a small debt, traffic goes first and the refresh waits for a gap. With a moderate debt, refresh work takes the slot and new traffic to the affected banks is held off. With the maximum debt, no traffic is accepted. A waiting transaction to an affected bank is then dropped with a retry pulse, and the bank is precharged and refreshed. Each bank has its own timers for its refresh blocking window and its precharge recovery. A per-bank refresh therefore closes only one bank, and the other banks keep serving traffic. The arbiter refreshes every bank at once only after the channel has been idle for a set number of cycles.

Top module: `refresh_cmd_arbiter`

## Requirements
- R1: After reset, `cmd_out` is NOP (0), `ab_ack` and `pb_ack` are 0, and no transaction is accepted until the first decision edge.
- R2: `cmd_out` encodes NOP=0, ACT=1, RD=2, WR=3, PRE=4, all-bank refresh=5, per-bank refresh=6. A transaction (`txn_cmd` ACT=0, RD=1, WR=2, PRE=3) is issued as `txn_cmd+1` to `txn_bank`. With `ref_debt` below `URG_LVL`, an issuable transaction takes the slot ahead of a ready refresh. With no issuable transaction, the refresh issues as soon as its banks are closed and free.
- R3: With debt below `URG_LVL`, a transaction to a target bank whose row is open is still issued. The arbiter precharges the lowest open target bank itself only in a cycle with no valid transaction.
- R4: With debt from `URG_LVL` up to `CRIT_LVL-1` and a refresh pending, a ready refresh or a needed precharge takes the slot. A transaction to a target bank is never accepted. A transaction to any other bank is accepted only when the refresh side has nothing to issue.
- R5: With debt at or above `CRIT_LVL` and a refresh pending, no transaction is accepted. A valid transaction to a target bank gets `txn_retry` high instead of `txn_ready`, which drops it. Open target banks are precharged.
- R6: No refresh reaches a bank until `T_RP` cycles after a precharge to that bank. The refresh may appear at the earliest `T_RP` cycles after the precharge cycle.
- R7: A per-bank refresh to bank b blocks every command to b for `T_RFCPB` cycles. A command to b may appear `T_RFCPB` cycles after the refresh cycle, and other banks stay eligible throughout. Open rows in non-target banks do not delay a per-bank refresh.
- R8: An all-bank refresh blocks every bank for `T_RFC` cycles.
- R9: The channel counts as idle after `IDLE_LIM` consecutive cycles with `txn_valid` low. The refresh type is all-bank when idle and per-bank at `pb_target` otherwise.
- R10: At most one command is issued per cycle. `ab_ack` or `pb_ack` pulses, with `ack_bank`, in exactly the cycle its refresh command appears on `cmd_out`, and the two acknowledges are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pend | input | 1 | A refresh is owed |
| ref_debt | input | DEBT_W | Number of refreshes currently owed |
| pb_target | input | BANK_W | Lowest bank still owed a per-bank refresh |
| row_open | input | NB | Bit per bank, 1 when a row is open |
| txn_valid | input | 1 | Pending transaction present |
| txn_cmd | input | 2 | Transaction type: ACT=0, RD=1, WR=2, PRE=3 |
| txn_bank | input | BANK_W | Transaction bank |
| txn_ready | output | 1 | Transaction accepted and issued this cycle |
| txn_retry | output | 1 | Transaction dropped; replay after the refresh |
| cmd_out | output | 3 | Issued command (encoding in R2) |
| cmd_bank | output | BANK_W | Bank of the issued command |
| ab_ack | output | 1 | All-bank refresh issued |
| pb_ack | output | 1 | Per-bank refresh issued |
| ack_bank | output | BANK_W | Bank index carried with the acknowledge |

## Verification
The decision matrix is applied one cycle after a clean reset. It covers no pending refresh, low debt, moderate debt and maximum debt, each with the target bank open or closed and with the transaction addressed to the target bank or to another bank. These cases separate traffic-first, precharge-first, refresh-first and drop-with-retry. Directed sequences then measure the exact cycle at which a blocked bank frees after a per-bank refresh, after an all-bank refresh and after a precharge. They also check that an unrelated bank keeps flowing during a per-bank window. Two idle runs, one cycle apart in length, show where the refresh type switches from per-bank to all-bank.

// File: rtl/rfarb_pkg.sv
package rfarb_pkg;
  typedef enum logic [2:0] {
    C_NOP   = 3'd0,
    C_ACT   = 3'd1,
    C_RD    = 3'd2,
    C_WR    = 3'd3,
    C_PRE   = 3'd4,
    C_REFAB = 3'd5,
    C_REFPB = 3'd6
  } dcmd_e;

  typedef enum logic [1:0] {
    T_ACT = 2'd0,
    T_RD  = 2'd1,
    T_WR  = 2'd2,
    T_PRE = 2'd3
  } tcmd_e;

  typedef enum logic [1:0] {
    S_NONE = 2'd0,
    S_TXN  = 2'd1,
    S_REF  = 2'd2,
    S_PRE  = 2'd3
  } slot_e;
endpackage

// File: rtl/rfarb_downcnt.sv
module rfarb_downcnt #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         busy
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = val;
    else if (cnt_q != '0)  cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/rfarb_idle_mon.sv
module rfarb_idle_mon #(
  parameter int LIM = 16,
  localparam int W = $clog2(LIM + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic idle
);
  logic [W-1:0] cnt_q, cnt_d;

  assign idle = (cnt_q == W'(LIM));

  always_comb begin
    cnt_d = cnt_q;
    if (active)     cnt_d = '0;
    else if (!idle) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfarb_lowest.sv
module rfarb_lowest #(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/refresh_cmd_arbiter.sv
module refresh_cmd_arbiter
  import rfarb_pkg::*;
#(
  parameter int NB       = 32,
  parameter int T_RFC    = 440,
  parameter int T_RFCPB  = 140,
  parameter int T_RP     = 14,
  parameter int IDLE_LIM = 16,
  parameter int DEBT_W   = 4,
  parameter int URG_LVL  = 4,
  parameter int CRIT_LVL = 8,
  localparam int BANK_W  = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_pend,
  input  logic [DEBT_W-1:0] ref_debt,
  input  logic [BANK_W-1:0] pb_target,
  input  logic [NB-1:0]     row_open,
  input  logic              txn_valid,
  input  logic [1:0]        txn_cmd,
  input  logic [BANK_W-1:0] txn_bank,
  output logic              txn_ready,
  output logic              txn_retry,
  output logic [2:0]        cmd_out,
  output logic [BANK_W-1:0] cmd_bank,
  output logic              ab_ack,
  output logic              pb_ack,
  output logic [BANK_W-1:0] ack_bank
);
  localparam int BLK_W = $clog2(T_RFC + 1);
  localparam int RP_W  = $clog2(T_RP + 1);
  localparam logic [NB-1:0] ONE_BANK = NB'(1);

  logic              idle;
  logic [NB-1:0]     blk_busy, rp_busy, ld_blk, ld_rp;
  logic [NB-1:0]     tgt_mask, pre_cand;
  logic              pre_any;
  logic [BANK_W-1:0] pre_idx;
  logic              lvl_urg, lvl_crit, ref_clear, ref_go, txn_tgt, txn_fit;
  logic [BLK_W-1:0]  blk_val;
  slot_e             slot;

  logic [2:0]        cmd_d;
  logic [BANK_W-1:0] bank_d, ackb_d;
  logic              ab_d, pb_d;

  // Idle detection selects the refresh type
  rfarb_idle_mon #(.LIM(IDLE_LIM)) u_idle (
    .clk(clk), .rst_n(rst_n), .active(txn_valid), .idle(idle)
  );

  assign tgt_mask  = idle ? {NB{1'b1}} : (ONE_BANK << pb_target);
  assign lvl_urg   = ref_pend && (ref_debt >= DEBT_W'(URG_LVL));
  assign lvl_crit  = ref_pend && (ref_debt >= DEBT_W'(CRIT_LVL));
  assign ref_clear = ~|(tgt_mask & (blk_busy | rp_busy | row_open));
  assign ref_go    = ref_pend && ref_clear;
  assign pre_cand  = tgt_mask & row_open & ~rp_busy & ~blk_busy;
  assign txn_tgt   = tgt_mask[txn_bank];

  rfarb_lowest #(.N(NB)) u_pick (
    .req(pre_cand), .any(pre_any), .idx(pre_idx)
  );

  always_comb begin
    txn_fit = txn_valid && !blk_busy[txn_bank]
              && !(tcmd_e'(txn_cmd) == T_ACT && rp_busy[txn_bank])
              && !(lvl_urg && txn_tgt) && !lvl_crit;
  end

  // Slot decision: debt level orders the three sources
  always_comb begin
    slot = S_NONE;
    if (lvl_crit) begin
      if (ref_go)       slot = S_REF;
      else if (pre_any) slot = S_PRE;
    end else if (lvl_urg) begin
      if (ref_go)       slot = S_REF;
      else if (pre_any) slot = S_PRE;
      else if (txn_fit) slot = S_TXN;
    end else begin
      if (txn_fit)      slot = S_TXN;
      else if (ref_go)  slot = S_REF;
      else if (ref_pend && pre_any && !txn_valid) slot = S_PRE;
    end
  end

  assign txn_ready = (slot == S_TXN);
  assign txn_retry = lvl_crit && txn_valid && txn_tgt;

  // Next command and acknowledge
  always_comb begin
    cmd_d  = C_NOP;
    bank_d = '0;
    ab_d   = 1'b0;
    pb_d   = 1'b0;
    ackb_d = '0;
    case (slot)
      S_TXN: begin
        cmd_d  = 3'(txn_cmd) + 3'd1;
        bank_d = txn_bank;
      end
      S_PRE: begin
        cmd_d  = C_PRE;
        bank_d = pre_idx;
      end
      S_REF: begin
        if (idle) begin
          cmd_d = C_REFAB;
          ab_d  = 1'b1;
        end else begin
          cmd_d  = C_REFPB;
          bank_d = pb_target;
          pb_d   = 1'b1;
          ackb_d = pb_target;
        end
      end
      default: ;
    endcase
  end

  assign blk_val = idle ? BLK_W'(T_RFC - 1) : BLK_W'(T_RFCPB - 1);

  // Per-bank blocking window and precharge recovery timers
  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign ld_blk[b] = (slot == S_REF) && tgt_mask[b];
    assign ld_rp[b]  = ((slot == S_PRE) && (pre_idx == BANK_W'(b)))
                    || ((slot == S_TXN) && (tcmd_e'(txn_cmd) == T_PRE)
                        && (txn_bank == BANK_W'(b)));

    rfarb_downcnt #(.W(BLK_W)) u_blk (
      .clk(clk), .rst_n(rst_n), .load(ld_blk[b]), .val(blk_val),
      .busy(blk_busy[b])
    );
    rfarb_downcnt #(.W(RP_W)) u_rp (
      .clk(clk), .rst_n(rst_n), .load(ld_rp[b]), .val(RP_W'(T_RP - 1)),
      .busy(rp_busy[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_out  <= C_NOP;
      cmd_bank <= '0;
      ab_ack   <= 1'b0;
      pb_ack   <= 1'b0;
      ack_bank <= '0;
    end else begin
      cmd_out  <= cmd_d;
      cmd_bank <= bank_d;
      ab_ack   <= ab_d;
      pb_ack   <= pb_d;
      ack_bank <= ackb_d;
    end
  end
endmodule

// File: rtl/refresh_cmd_arbiter_chk.sv
module refresh_cmd_arbiter_chk #(
  parameter int DEBT_W   = 4,
  parameter int BANK_W   = 5,
  parameter int URG_LVL  = 4,
  parameter int CRIT_LVL = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_pend,
  input logic [DEBT_W-1:0] ref_debt,
  input logic [BANK_W-1:0] pb_target,
  input logic [BANK_W-1:0] txn_bank,
  input logic              txn_ready,
  input logic              txn_retry,
  input logic [2:0]        cmd_out,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              ab_ack,
  input logic              pb_ack,
  input logic [BANK_W-1:0] ack_bank
);
  // R5
  crit_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pend && ref_debt >= DEBT_W'(CRIT_LVL)) |-> !txn_ready);
  // R5
  retry_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(txn_ready && txn_retry));
  // R4
  urg_target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pend && ref_debt >= DEBT_W'(URG_LVL) && txn_ready) |-> (txn_bank != pb_target));
  // R6
  rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out == 3'd4) |=> (cmd_out != 3'd5) && !(cmd_out == 3'd6 && cmd_bank == $past(cmd_bank)));
  // R7
  pb_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out == 3'd6) |=> !(cmd_out >= 3'd1 && cmd_out <= 3'd4 && cmd_bank == $past(cmd_bank)));
  // R8
  ab_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out == 3'd5) |=> !(cmd_out >= 3'd1 && cmd_out <= 3'd4));
  // R10
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ab_ack, pb_ack}));
  // R10
  ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_ack |-> (cmd_out == 3'd6 && ack_bank == cmd_bank)) and (ab_ack |-> cmd_out == 3'd5));
endmodule

bind refresh_cmd_arbiter refresh_cmd_arbiter_chk #(
  .DEBT_W(DEBT_W), .BANK_W(BANK_W), .URG_LVL(URG_LVL), .CRIT_LVL(CRIT_LVL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_pend(ref_pend), .ref_debt(ref_debt),
  .pb_target(pb_target), .txn_bank(txn_bank), .txn_ready(txn_ready),
  .txn_retry(txn_retry), .cmd_out(cmd_out), .cmd_bank(cmd_bank),
  .ab_ack(ab_ack), .pb_ack(pb_ack), .ack_bank(ack_bank)
);

// File: tb/tb_refresh_cmd_arbiter.sv
module tb_refresh_cmd_arbiter;
  localparam int NB = 8, T_RFC = 20, T_RFCPB = 8, T_RP = 4, IDLE_LIM = 6;

  logic       clk, rst_n, ref_pend, txn_valid, txn_ready, txn_retry;
  logic [3:0] ref_debt;
  logic [2:0] pb_target, txn_bank, cmd_bank, ack_bank, cmd_out;
  logic [7:0] row_open;
  logic [1:0] txn_cmd;
  logic       ab_ack, pb_ack;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  refresh_cmd_arbiter #(.NB(NB), .T_RFC(T_RFC), .T_RFCPB(T_RFCPB), .T_RP(T_RP),
    .IDLE_LIM(IDLE_LIM)) dut (
    .clk(clk), .rst_n(rst_n), .ref_pend(ref_pend), .ref_debt(ref_debt),
    .pb_target(pb_target), .row_open(row_open), .txn_valid(txn_valid),
    .txn_cmd(txn_cmd), .txn_bank(txn_bank), .txn_ready(txn_ready),
    .txn_retry(txn_retry), .cmd_out(cmd_out), .cmd_bank(cmd_bank),
    .ab_ack(ab_ack), .pb_ack(pb_ack), .ack_bank(ack_bank));

  initial clk = 0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic pend; logic [3:0] debt; logic [2:0] tgt; logic [7:0] opn;
    logic vld; logic [1:0] tc; logic [2:0] tb;
    logic rdy; logic rty; logic [2:0] ec; logic [2:0] eb;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{1'b0, 4'd0, 3'd0, 8'h00, 1'b1, 2'd1, 3'd2, 1'b1, 1'b0, 3'd2, 3'd2},
    '{1'b1, 4'd0, 3'd3, 8'h00, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 3'd6, 3'd3},
    '{1'b1, 4'd2, 3'd3, 8'h00, 1'b1, 2'd2, 3'd3, 1'b1, 1'b0, 3'd3, 3'd3},
    '{1'b1, 4'd2, 3'd3, 8'h08, 1'b1, 2'd1, 3'd3, 1'b1, 1'b0, 3'd2, 3'd3},
    '{1'b1, 4'd2, 3'd3, 8'h08, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 3'd4, 3'd3},
    '{1'b1, 4'd5, 3'd3, 8'h00, 1'b1, 2'd1, 3'd1, 1'b0, 1'b0, 3'd6, 3'd3},
    '{1'b1, 4'd5, 3'd3, 8'h08, 1'b1, 2'd1, 3'd3, 1'b0, 1'b0, 3'd4, 3'd3},
    '{1'b1, 4'd6, 3'd3, 8'h08, 1'b1, 2'd1, 3'd1, 1'b0, 1'b0, 3'd4, 3'd3},
    '{1'b1, 4'd8, 3'd3, 8'h08, 1'b1, 2'd1, 3'd3, 1'b0, 1'b1, 3'd4, 3'd3},
    '{1'b1, 4'd8, 3'd3, 8'h00, 1'b1, 2'd0, 3'd5, 1'b0, 1'b0, 3'd6, 3'd3},
    '{1'b0, 4'd0, 3'd0, 8'h00, 1'b1, 2'd3, 3'd6, 1'b1, 1'b0, 3'd4, 3'd6},
    '{1'b1, 4'd1, 3'd7, 8'h00, 1'b1, 2'd0, 3'd0, 1'b1, 1'b0, 3'd1, 3'd0},
    '{1'b1, 4'd4, 3'd2, 8'h20, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 3'd6, 3'd2}
  };
  string vtag [13] = '{"R2", "R2", "R2", "R3", "R3", "R4", "R4", "R4",
                       "R5", "R5", "R2", "R2", "R7"};

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 0; ref_pend = 0; ref_debt = 0; pb_target = 0; row_open = 0;
    txn_valid = 0; txn_cmd = 0; txn_bank = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    if (!done) begin
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int j;
    // R1 reset state
    do_reset();
    chk("R1 cmd", cmd_out, 0);
    chk("R1 ab_ack", ab_ack, 0);
    chk("R1 pb_ack", pb_ack, 0);

    // Decision matrix, one cycle after reset each
    for (int i = 0; i < 13; i++) begin
      do_reset();
      ref_pend = VEC[i].pend; ref_debt = VEC[i].debt; pb_target = VEC[i].tgt;
      row_open = VEC[i].opn; txn_valid = VEC[i].vld; txn_cmd = VEC[i].tc;
      txn_bank = VEC[i].tb;
      #1;
      chk({vtag[i], " ready"}, txn_ready, VEC[i].rdy);
      chk({vtag[i], " retry"}, txn_retry, VEC[i].rty);
      tick();
      chk({vtag[i], " cmd"}, cmd_out, VEC[i].ec);
      chk({vtag[i], " bank"}, cmd_bank, VEC[i].eb);
      chk("R10 ab_ack", ab_ack, int'(VEC[i].ec == 3'd5));
      chk("R10 pb_ack", pb_ack, int'(VEC[i].ec == 3'd6));
    end

    // R7: per-bank window on bank 2, bank 4 keeps flowing
    do_reset();
    ref_pend = 1; pb_target = 2;
    tick();
    chk("R10 pb_ack", pb_ack, 1);
    chk("R10 ack_bank", ack_bank, 2);
    ref_pend = 0; txn_valid = 1; txn_cmd = 1; txn_bank = 4;
    #1 chk("R7 other bank ready", txn_ready, 1);
    tick();
    chk("R7 other bank cmd", cmd_out, 2);
    txn_bank = 2; j = 2;
    #1;
    while (!txn_ready && j < 100) begin tick(); j++; #1; end
    chk("R7 window length", j, T_RFCPB);
    tick(); txn_valid = 0;

    // R9: one cycle short of idle still picks per-bank
    do_reset();
    repeat (IDLE_LIM - 1) tick();
    ref_pend = 1; pb_target = 5;
    tick();
    chk("R9 not idle", cmd_out, 6);

    // R8/R9: idle picks all-bank, blocks every bank
    do_reset();
    repeat (IDLE_LIM) tick();
    ref_pend = 1;
    tick();
    chk("R9 idle all-bank", cmd_out, 5);
    chk("R10 ab_ack", ab_ack, 1);
    chk("R10 pb_ack quiet", pb_ack, 0);
    ref_pend = 0; txn_valid = 1; txn_cmd = 1; txn_bank = 6; j = 1;
    #1;
    while (!txn_ready && j < 100) begin tick(); j++; #1; end
    chk("R8 window length", j, T_RFC);
    tick(); txn_valid = 0;

    // R6: precharge recovery before refresh
    do_reset();
    ref_pend = 1; ref_debt = 5; pb_target = 1; row_open = 8'h02;
    tick();
    chk("R6 precharge", cmd_out, 4);
    chk("R6 precharge bank", cmd_bank, 1);
    row_open = 0; j = 0;
    while (cmd_out != 3'd6 && j < 100) begin tick(); j++; end
    chk("R6 recovery length", j, T_RP);

    // R4: refresh side waiting, other bank accepted
    do_reset();
    ref_pend = 1; ref_debt = 5; pb_target = 1; row_open = 8'h02;
    tick();
    row_open = 0; txn_valid = 1; txn_cmd = 1; txn_bank = 5;
    #1 chk("R4 other bank while waiting", txn_ready, 1);
    tick();
    chk("R4 other bank cmd", cmd_out, 2);
    chk("R4 other bank id", cmd_bank, 5);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule